// File: doc/BRIEF.md
# RTC Alarm and Interrupt Event Unit

This unit gathers the event sources of a real-time clock onto one interrupt line. There are five sources: calibration launched, calibration complete, compare hit, one-second tick and alarm. Each source sets a sticky bit in an event register. Software clears a bit by writing a 1 to it. A per-bit enable mask decides which sticky bits drive the interrupt. A separate status view shows the raw level of each source. Software can sample that view before and after reading the calendar, which tells it whether a second rolled over during the read.

The unit also holds the alarm comparator. Two programmable words, an alarm time and an alarm date, use the same BCD layout as the running calendar. They are compared against the live calendar words every cycle. The event register has a write-only command bit, bit 31. Writing a 1 to it emits a one-cycle pulse that tells the calendar to load its configured time and date. The calendar counter and the bus decoder sit outside this unit. They drive the time and date words and the write strobes.

Top module: `rtc_evt_unit`

## Requirements
- R1: Every event-style view uses one bit layout: bit0 calibration launched, bit1 calibration complete, bit2 compare, bit3 one-second tick, bit4 alarm. This applies to the event readback, the enable readback and the status readback. Bits 5 to 31 of these readbacks, bit 31 included, always read 0.
- R2: A high source bit i (bits 0 to 3 come from `src_evt`) sets event bit i at the next clock edge. The bit stays set until software clears it.
- R3: A cycle with `wr_evt` high and `wdata[i]`=1 clears event bit i, so the readback shows 0 one cycle later. Event bits written with 0 keep their value.
- R4: If a set and a clear reach the same event bit in the same cycle, the bit ends up set.
- R5: Status bits 0 to 3 show the level of `src_evt` in the previous cycle. Status bit 4 shows whether the live time and date equalled the alarm words in the previous cycle. Clearing event bits does not change the status view.
- R6: A write with `wr_evt` high and `wdata[31]`=1 produces `upd_pulse` high for exactly one cycle, the cycle after the write. Holding that write for further cycles gives no further pulse.
- R7: `wr_alm_time` loads the alarm time from `wdata[20:0]` and `wr_alm_date` loads the alarm date from `wdata[18:0]`. Both read back one cycle later. After reset both words are all ones, which no valid BCD calendar value can equal.
- R8: The alarm event bit is set once, at the edge after the live time and date first equal the alarm words. It is not set again while they stay equal. It re-arms once they differ.
- R9: If the time matches but the date does not, the alarm event bit is not set.
- R10: `irq` is high exactly when some bit 0 to 4 is set in both the event register and the enable register. `wr_en` loads the enable register from `wdata[4:0]`.
- R11: After reset the event, enable and status views read 0, and `irq` and `upd_pulse` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_evt | input | 4 | Source pulses: calibration launched, calibration complete, compare, one-second |
| cur_time | input | 21 | Live calendar time word (BCD seconds, minutes, hours) |
| cur_date | input | 19 | Live calendar date word (BCD day, month, year) |
| wr_evt | input | 1 | Write strobe for the event register (write-one-to-clear, bit 31 update command) |
| wr_en | input | 1 | Write strobe for the enable mask |
| wr_alm_time | input | 1 | Write strobe for the alarm time word |
| wr_alm_date | input | 1 | Write strobe for the alarm date word |
| wdata | input | 32 | Write data shared by all strobes |
| irq | output | 1 | Interrupt line |
| upd_pulse | output | 1 | One-cycle command to the calendar to load its configured time and date |
| evt_rd | output | 32 | Event register readback |
| en_rd | output | 32 | Enable register readback |
| sts_rd | output | 32 | Raw status readback |
| alm_time_rd | output | 21 | Alarm time readback |
| alm_date_rd | output | 19 | Alarm date readback |

## Verification
Every output comes from a register, so each result is due one cycle after the stimulus: event bits, status bits, the enable mask, the alarm words, the update pulse and the interrupt all appear at the edge that follows the input cycle. The driver applies each stimulus at a falling edge and queues its expected readbacks with a due cycle one higher than the current count. The monitor compares them at the falling edge of that cycle, away from the edge where the registers change. The multi-cycle cases are built as runs of single-cycle steps, each with its own one-cycle expectations: a held update write, an alarm that stays equal after its clear, and an alarm that re-arms.

// File: rtl/rtc_evt_pkg.sv
package rtc_evt_pkg;
    localparam int NUM_EVT   = 5;
    localparam int EV_CAL_GO = 0;
    localparam int EV_CAL_OK = 1;
    localparam int EV_CMP    = 2;
    localparam int EV_SEC    = 3;
    localparam int EV_ALM    = 4;
    localparam int NUM_SRC   = EV_ALM;

    typedef logic [NUM_EVT-1:0] evt_vec_t;
endpackage

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
    parameter int TIME_W = 21,
    parameter int DATE_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_time,
    input  logic              wr_date,
    input  logic [TIME_W-1:0] time_wdata,
    input  logic [DATE_W-1:0] date_wdata,
    input  logic [TIME_W-1:0] cur_time,
    input  logic [DATE_W-1:0] cur_date,
    output logic [TIME_W-1:0] alm_time_o,
    output logic [DATE_W-1:0] alm_date_o,
    output logic              eq_o,
    output logic              rise_o
);
    typedef struct packed {
        logic [TIME_W-1:0] atime;
        logic [DATE_W-1:0] adate;
        logic              hit;
    } alm_st_t;

    alm_st_t st_d, st_q;
    logic    eq_now;

    always_comb begin
        st_d   = st_q;
        eq_now = (cur_time == st_q.atime) && (cur_date == st_q.adate);
        if (wr_time) begin
            st_d.atime = time_wdata;
        end
        if (wr_date) begin
            st_d.adate = date_wdata;
        end
        st_d.hit = eq_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.atime <= '1;
            st_q.adate <= '1;
            st_q.hit   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign eq_o       = eq_now;
    assign rise_o     = eq_now & ~st_q.hit;
    assign alm_time_o = st_q.atime;
    assign alm_date_o = st_q.adate;

    AST_ALM_SINGLE_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o) else $error("alarm fired twice in a row"); // R8
endmodule

// File: rtl/rtc_evt_bank.sv
module rtc_evt_bank
    import rtc_evt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  evt_vec_t set_i,
    input  evt_vec_t lvl_i,
    input  logic     wr_evt,
    input  logic     wr_en,
    input  evt_vec_t clr_data,
    input  logic     upd_data,
    input  evt_vec_t en_data,
    output evt_vec_t evt_o,
    output evt_vec_t en_o,
    output evt_vec_t sts_o,
    output logic     irq_o,
    output logic     upd_o
);
    typedef struct packed {
        evt_vec_t evt;
        evt_vec_t en;
        evt_vec_t sts;
        logic     upd;
        logic     upd_req;
    } bank_st_t;

    bank_st_t st_d, st_q;
    evt_vec_t clr_mask;
    evt_vec_t evt_nx;
    logic     upd_req_now;

    assign clr_mask    = wr_evt ? clr_data : '0;
    assign upd_req_now = wr_evt & upd_data;

    for (genvar b = 0; b < NUM_EVT; b++) begin : g_bit
        assign evt_nx[b] = set_i[b] | (st_q.evt[b] & ~clr_mask[b]);
    end

    always_comb begin
        st_d         = st_q;
        st_d.evt     = evt_nx;
        st_d.sts     = lvl_i;
        st_d.upd_req = upd_req_now;
        st_d.upd     = upd_req_now & ~st_q.upd_req;
        if (wr_en) begin
            st_d.en = en_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign evt_o = st_q.evt;
    assign en_o  = st_q.en;
    assign sts_o = st_q.sts;
    assign upd_o = st_q.upd;
    assign irq_o = |(st_q.evt & st_q.en);

    AST_EVT_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((evt_o & $past(set_i)) == $past(set_i))) else $error("set lost"); // R2
    AST_EVT_CLEAR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_mask & ~set_i)) |=> ((evt_o & $past(clr_mask & ~set_i)) == '0)) else $error("clear lost"); // R3
    AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_mask & set_i)) |=> ((evt_o & $past(clr_mask & set_i)) != '0)) else $error("clear beat set"); // R4
    AST_UPD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |=> !upd_o) else $error("update pulse too long"); // R6
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (en_o != '0)) else $error("irq without enable"); // R10
endmodule

// File: rtl/rtc_evt_unit.sv
module rtc_evt_unit
    import rtc_evt_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int TIME_W  = 21,
    parameter int DATE_W  = 19,
    parameter int UPD_BIT = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_SRC-1:0] src_evt,
    input  logic [TIME_W-1:0] cur_time,
    input  logic [DATE_W-1:0] cur_date,
    input  logic              wr_evt,
    input  logic              wr_en,
    input  logic              wr_alm_time,
    input  logic              wr_alm_date,
    input  logic [DATA_W-1:0] wdata,
    output logic              irq,
    output logic              upd_pulse,
    output logic [DATA_W-1:0] evt_rd,
    output logic [DATA_W-1:0] en_rd,
    output logic [DATA_W-1:0] sts_rd,
    output logic [TIME_W-1:0] alm_time_rd,
    output logic [DATE_W-1:0] alm_date_rd
);
    logic     alm_eq;
    logic     alm_rise;
    evt_vec_t set_vec;
    evt_vec_t lvl_vec;
    evt_vec_t evt_v;
    evt_vec_t en_v;
    evt_vec_t sts_v;
    logic     unused_wdata;

    assign unused_wdata = ^wdata;
    assign set_vec = {alm_rise, src_evt};
    assign lvl_vec = {alm_eq, src_evt};

    rtc_alarm_match #(
        .TIME_W(TIME_W),
        .DATE_W(DATE_W)
    ) u_alarm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_time    (wr_alm_time),
        .wr_date    (wr_alm_date),
        .time_wdata (wdata[TIME_W-1:0]),
        .date_wdata (wdata[DATE_W-1:0]),
        .cur_time   (cur_time),
        .cur_date   (cur_date),
        .alm_time_o (alm_time_rd),
        .alm_date_o (alm_date_rd),
        .eq_o       (alm_eq),
        .rise_o     (alm_rise)
    );

    rtc_evt_bank u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (set_vec),
        .lvl_i    (lvl_vec),
        .wr_evt   (wr_evt),
        .wr_en    (wr_en),
        .clr_data (wdata[NUM_EVT-1:0]),
        .upd_data (wdata[UPD_BIT]),
        .en_data  (wdata[NUM_EVT-1:0]),
        .evt_o    (evt_v),
        .en_o     (en_v),
        .sts_o    (sts_v),
        .irq_o    (irq),
        .upd_o    (upd_pulse)
    );

    assign evt_rd = DATA_W'(evt_v);
    assign en_rd  = DATA_W'(en_v);
    assign sts_rd = DATA_W'(sts_v);

    AST_UPD_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        upd_pulse |-> $past(wr_evt && wdata[UPD_BIT])) else $error("stray update pulse"); // R6
endmodule

// File: tb/sim_rtc_evt_unit.sv
module sim_rtc_evt_unit;
    localparam int CLK_PER = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  src_evt = '0;
    logic [20:0] cur_time = '0;
    logic [18:0] cur_date = '0;
    logic        wr_evt = 1'b0, wr_en = 1'b0, wr_alm_time = 1'b0, wr_alm_date = 1'b0;
    logic [31:0] wdata = '0;
    logic        irq, upd_pulse;
    logic [31:0] evt_rd, en_rd, sts_rd;
    logic [20:0] alm_time_rd;
    logic [18:0] alm_date_rd;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int          due;
        int          sel;
        logic [31:0] val;
        string       tag;
    } item_t;
    item_t sb[$];

    localparam int S_EVT = 0, S_STS = 1, S_EN = 2, S_IRQ = 3, S_UPD = 4, S_AT = 5, S_AD = 6;
    localparam logic [20:0] AT = {7'h12, 7'h34, 7'h56};
    localparam logic [18:0] AD = {8'h25, 5'h06, 6'h15};

    rtc_evt_unit u0 (
        .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .cur_time(cur_time), .cur_date(cur_date),
        .wr_evt(wr_evt), .wr_en(wr_en), .wr_alm_time(wr_alm_time), .wr_alm_date(wr_alm_date),
        .wdata(wdata), .irq(irq), .upd_pulse(upd_pulse), .evt_rd(evt_rd), .en_rd(en_rd),
        .sts_rd(sts_rd), .alm_time_rd(alm_time_rd), .alm_date_rd(alm_date_rd)
    );

    always #(CLK_PER/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] probe(int sel);
        case (sel)
            S_EVT:   return evt_rd;
            S_STS:   return sts_rd;
            S_EN:    return en_rd;
            S_IRQ:   return {31'b0, irq};
            S_UPD:   return {31'b0, upd_pulse};
            S_AT:    return {11'b0, alm_time_rd};
            default: return {13'b0, alm_date_rd};
        endcase
    endfunction

    function automatic void expect1(int sel, logic [31:0] v, string tag);
        item_t it;
        it.due = cyc + 1;
        it.sel = sel;
        it.val = v;
        it.tag = tag;
        sb.push_back(it);
    endfunction

    always @(negedge clk) begin
        item_t it;
        logic [31:0] got;
        while (sb.size() > 0 && sb[0].due == cyc) begin
            it  = sb.pop_front();
            got = probe(it.sel);
            total++;
            if (got !== it.val) begin
                bad++;
                $display("FAIL %s sel=%0d actual=%h expected=%h", it.tag, it.sel, got, it.val);
            end
        end
    end

    task automatic nxt();
        @(negedge clk);
        src_evt = '0; wr_evt = 1'b0; wr_en = 1'b0;
        wr_alm_time = 1'b0; wr_alm_date = 1'b0; wdata = '0;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11 / R7 reset values
        nxt();
        expect1(S_EVT, 32'h0, "R11 evt"); expect1(S_STS, 32'h0, "R11 sts");
        expect1(S_EN, 32'h0, "R11 en"); expect1(S_IRQ, 32'h0, "R11 irq");
        expect1(S_UPD, 32'h0, "R11 upd");
        expect1(S_AT, 32'h001F_FFFF, "R7 reset time"); expect1(S_AD, 32'h0007_FFFF, "R7 reset date");
        // R2 / R5 / R1 one-second source
        nxt(); src_evt = 4'b1000;
        expect1(S_EVT, 32'h08, "R2 set sec"); expect1(S_STS, 32'h08, "R5 sts sec");
        nxt();
        expect1(S_EVT, 32'h08, "R2 sticky"); expect1(S_STS, 32'h00, "R5 sts drop");
        nxt(); src_evt = 4'b0101;
        expect1(S_EVT, 32'h0D, "R1 bit order"); expect1(S_STS, 32'h05, "R5 sts mix");
        // R3 clear
        nxt(); wr_evt = 1'b1; wdata = 32'h08;
        expect1(S_EVT, 32'h05, "R3 clear one"); expect1(S_STS, 32'h00, "R5 sts unaffected");
        // R4 set wins
        nxt(); src_evt = 4'b0010; wr_evt = 1'b1; wdata = 32'h03;
        expect1(S_EVT, 32'h06, "R4 set beats clear");
        // R10 enable mask
        nxt(); wr_en = 1'b1; wdata = 32'hFFFF_FFF0;
        expect1(S_EN, 32'h10, "R10 en load"); expect1(S_IRQ, 32'h0, "R10 masked");
        nxt(); wr_en = 1'b1; wdata = 32'h04;
        expect1(S_IRQ, 32'h1, "R10 irq on");
        // R6 update pulse, strobe held two cycles
        nxt(); wr_evt = 1'b1; wdata = 32'h8000_0000;
        expect1(S_UPD, 32'h1, "R6 pulse"); expect1(S_EVT, 32'h06, "R6 bit31 reads 0");
        @(negedge clk);
        expect1(S_UPD, 32'h0, "R6 held no repeat");
        nxt();
        expect1(S_UPD, 32'h0, "R6 idle");
        nxt(); wr_evt = 1'b1; wdata = 32'h1F;
        expect1(S_EVT, 32'h0, "R3 clear all"); expect1(S_IRQ, 32'h0, "R10 irq off");
        // R7 alarm words
        nxt(); wr_alm_time = 1'b1; wdata = {11'h7FF, AT};
        expect1(S_AT, {11'b0, AT}, "R7 time rb");
        nxt(); wr_alm_date = 1'b1; wdata = {13'h0, AD};
        expect1(S_AD, {13'b0, AD}, "R7 date rb");
        // R9 date differs
        nxt(); cur_time = AT; cur_date = AD ^ 19'h1;
        expect1(S_EVT, 32'h0, "R9 no alarm"); expect1(S_STS, 32'h0, "R9 sts");
        // R8 match
        nxt(); cur_date = AD;
        expect1(S_EVT, 32'h10, "R8 alarm"); expect1(S_STS, 32'h10, "R5 sts alarm");
        nxt();
        expect1(S_EVT, 32'h10, "R8 held");
        nxt(); wr_evt = 1'b1; wdata = 32'h10;
        expect1(S_EVT, 32'h0, "R3 clear alarm");
        nxt();
        expect1(S_EVT, 32'h0, "R8 no refire"); expect1(S_STS, 32'h10, "R5 still equal");
        nxt(); cur_time = AT + 21'h1;
        expect1(S_EVT, 32'h0, "R8 differ"); expect1(S_STS, 32'h0, "R5 differ");
        nxt(); cur_time = AT;
        expect1(S_EVT, 32'h10, "R8 rearm");
        nxt(); wr_en = 1'b1; wdata = 32'h10;
        expect1(S_IRQ, 32'h1, "R10 alarm irq");
        repeat (3) nxt();
        if (sb.size() != 0) begin
            total++; bad++;
            $display("FAIL scoreboard left=%0d actual=%0d expected=0", sb.size(), sb.size());
        end
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            finish_run();
        end
    end
endmodule